// File: doc/BRIEF.md
# Snooping Write-Back Data Cache

This block places a small direct-mapped write-back cache in front of a local SRAM for a CPU, while a DMA master shares the same SRAM through a second request port. Each DMA access goes through the cache's tag lookup first. A DMA read that hits a cached line gets the cached word, even when that word is newer than the SRAM, and the line is not written back. A DMA write goes to the SRAM and, when the location is cached, also into the line. This keeps the CPU and DMA views coherent. Any other master that reads the SRAM directly may still see stale data until software issues a writeback command.

Both request ports use valid/ready. A request is taken on the clock edge where valid and ready are both high. The requester must hold valid and the payload stable until that edge. Only one request is in flight at a time, so ready is low from acceptance until the response. Each response is a one-cycle pulse with no back-pressure, and the requester must take it. For a write, the response is only an acknowledge. The maintenance command is a plain level: hold `cmd_req` (with `cmd_inv` selecting invalidate) until `cmd_done` pulses, then drop it.

The SRAM port is a plain synchronous single-port memory with no handshake. Read data appears one cycle after the read request.

Top module: `snoop_wb_cache`

## Requirements
- R1: A CPU write that hits updates the cached word and marks the line dirty. No SRAM write happens for it, and a later CPU read returns the new value.
- R2: A DMA read that hits returns the cached word, even if it is newer than the SRAM. No SRAM write happens in the cycle after the DMA read is accepted.
- R3: A DMA write always writes the SRAM in the cycle after acceptance, with the accepted address and data. If the location is cached, the cached word is also updated and the line's dirty state is left unchanged.
- R4: A DMA write that misses does not allocate a line. A following CPU access to that address performs a full four-word line fill.
- R5: A CPU miss to a valid dirty line first writes the four old words back to their old SRAM addresses, then reads the four words of the new line.
- R6: The writeback command visits every line. It writes back each dirty line's words, clears the dirty bits and keeps lines valid, then pulses `cmd_done` for one cycle. Repeating it at once writes nothing.
- R7: The writeback-invalidate command does the same writeback and also clears every valid bit, so the next CPU access to any line refills it from the SRAM.
- R8: When a DMA request is valid, the CPU request is not accepted in that cycle. Order of service when idle: DMA, then command, then CPU.
- R9: At most one request is accepted at a time, and at most one response pulses per cycle. Every read, from either port, returns the most recent value written by either port.
- R10: A word address splits into an offset in bits [1:0], a line index in bits [5:2] and a tag in the bits above. Two addresses with equal index and different tags share one line.
- R11: A DMA read that misses is served from the SRAM with a single read, using one-cycle read latency.
- R12: After reset all lines are invalid, and no response, SRAM access or `cmd_done` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | CPU request accepted this edge |
| cpu_req_we | input | 1 | CPU request is a write |
| cpu_req_addr | input | ADDR_W | CPU word address |
| cpu_req_wdata | input | DATA_W | CPU write data |
| cpu_rsp_valid | output | 1 | CPU response pulse |
| cpu_rsp_rdata | output | DATA_W | CPU read data |
| dma_req_valid | input | 1 | DMA request valid |
| dma_req_ready | output | 1 | DMA request accepted this edge |
| dma_req_we | input | 1 | DMA request is a write |
| dma_req_addr | input | ADDR_W | DMA word address |
| dma_req_wdata | input | DATA_W | DMA write data |
| dma_rsp_valid | output | 1 | DMA response pulse |
| dma_rsp_rdata | output | DATA_W | DMA read data |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data, one cycle after a read |
| cmd_req | input | 1 | Maintenance command request, held until done |
| cmd_inv | input | 1 | Command also invalidates all lines |
| cmd_done | output | 1 | Maintenance command complete pulse |

## Verification
A wrong dirty bit shows up at the SRAM port, either as a writeback that should not happen or as one that is missing. It becomes visible on the next conflicting miss or maintenance command. It can also appear as a stale word in the SRAM while a direct read would expect fresh data. A wrong valid bit or tag changes the number of SRAM reads that a CPU access causes. A word that should have been updated by a DMA write returns a stale value on the next read from either port, within a few cycles. Every SRAM write is compared, in the cycle it happens, against the latest value written by either port. A writeback carrying an old word is therefore caught at once.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_DRD,
    S_EVICT,
    S_FILL,
    S_FWAIT,
    S_WALK
  } scb_state_e;
endpackage

// File: rtl/scb_line_store.sv
module scb_line_store #(
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [IDX_W-1:0]               idx,
  output logic                           rd_valid,
  output logic                           rd_dirty,
  output logic [TAG_W-1:0]               rd_tag,
  output logic [WORDS-1:0][DATA_W-1:0]   rd_line,
  input  logic                           wr_en,
  input  logic [OFF_W-1:0]               wr_off,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           wr_dirty,
  input  logic                           fill_en,
  input  logic [TAG_W-1:0]               fill_tag,
  input  logic                           clr_en,
  input  logic                           clr_inv
);
  logic [LINES-1:0]                 valid_v;
  logic [LINES-1:0]                 dirty_v;
  logic [TAG_W-1:0]                 tag_a  [LINES];
  logic [WORDS-1:0][DATA_W-1:0]     line_a [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic                           sel;
    logic                           valid_q;
    logic                           dirty_q;
    logic [TAG_W-1:0]               tag_q;
    logic [WORDS-1:0][DATA_W-1:0]   line_q;

    assign sel = (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
      end else if (sel) begin
        if (fill_en) begin
          valid_q <= 1'b1;
          dirty_q <= 1'b0;
        end else if (clr_en) begin
          dirty_q <= 1'b0;
          if (clr_inv) valid_q <= 1'b0;
        end else if (wr_en && wr_dirty) begin
          dirty_q <= 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (sel && fill_en) tag_q <= fill_tag;
      if (sel && wr_en)   line_q[wr_off] <= wr_data;
    end

    assign valid_v[g] = valid_q;
    assign dirty_v[g] = dirty_q;
    assign tag_a[g]   = tag_q;
    assign line_a[g]  = line_q;
  end

  assign rd_valid = valid_v[idx];
  assign rd_dirty = dirty_v[idx];
  assign rd_tag   = tag_a[idx];
  assign rd_line  = line_a[idx];
endmodule

// File: rtl/scb_ctrl.sv
module scb_ctrl
  import scb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int OFF_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req_valid,
  output logic                          cpu_req_ready,
  input  logic                          cpu_req_we,
  input  logic [ADDR_W-1:0]             cpu_req_addr,
  input  logic [DATA_W-1:0]             cpu_req_wdata,
  output logic                          cpu_rsp_valid,
  output logic [DATA_W-1:0]             cpu_rsp_rdata,
  input  logic                          dma_req_valid,
  output logic                          dma_req_ready,
  input  logic                          dma_req_we,
  input  logic [ADDR_W-1:0]             dma_req_addr,
  input  logic [DATA_W-1:0]             dma_req_wdata,
  output logic                          dma_rsp_valid,
  output logic [DATA_W-1:0]             dma_rsp_rdata,
  output logic                          sram_en,
  output logic                          sram_we,
  output logic [ADDR_W-1:0]             sram_addr,
  output logic [DATA_W-1:0]             sram_wdata,
  input  logic [DATA_W-1:0]             sram_rdata,
  input  logic                          cmd_req,
  input  logic                          cmd_inv,
  output logic                          cmd_done,
  output logic [IDX_W-1:0]              st_idx,
  input  logic                          st_valid,
  input  logic                          st_dirty,
  input  logic [TAG_W-1:0]              st_tag,
  input  logic [WORDS-1:0][DATA_W-1:0]  st_line,
  output logic                          st_wr_en,
  output logic [OFF_W-1:0]              st_wr_off,
  output logic [DATA_W-1:0]             st_wr_data,
  output logic                          st_wr_dirty,
  output logic                          st_fill_en,
  output logic [TAG_W-1:0]              st_fill_tag,
  output logic                          st_clr_en,
  output logic                          st_clr_inv
);
  localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_LINE = IDX_W'(LINES - 1);

  scb_state_e         state;
  logic               r_dma, r_we, r_inv;
  logic [ADDR_W-1:0]  r_addr;
  logic [DATA_W-1:0]  r_wdata;
  logic [OFF_W-1:0]   cnt, cap_off, r_off;
  logic [IDX_W-1:0]   wl, r_idx;
  logic [TAG_W-1:0]   r_tag;
  logic               cap_v, hit, line_dirty;

  assign r_off      = r_addr[OFF_W-1:0];
  assign r_idx      = r_addr[OFF_W +: IDX_W];
  assign r_tag      = r_addr[ADDR_W-1 -: TAG_W];
  assign st_idx     = (state == S_WALK) ? wl : r_idx;
  assign hit        = st_valid && (st_tag == r_tag);
  assign line_dirty = st_valid && st_dirty;

  assign dma_req_ready = (state == S_IDLE);
  assign cpu_req_ready = (state == S_IDLE) && !dma_req_valid && !cmd_req;
  assign st_fill_tag   = r_tag;
  assign st_clr_inv    = r_inv;

  always_comb begin
    sram_en     = 1'b0;
    sram_we     = 1'b0;
    sram_addr   = r_addr;
    sram_wdata  = r_wdata;
    st_wr_en    = 1'b0;
    st_wr_off   = r_off;
    st_wr_data  = r_wdata;
    st_wr_dirty = 1'b0;
    st_fill_en  = 1'b0;
    st_clr_en   = 1'b0;
    unique case (state)
      S_LOOK: begin
        if (r_dma && r_we) begin
          sram_en  = 1'b1;
          sram_we  = 1'b1;
          st_wr_en = hit;
        end else if (r_dma) begin
          sram_en = !hit;
        end else begin
          st_wr_en    = hit && r_we;
          st_wr_dirty = 1'b1;
        end
      end
      S_EVICT: begin
        sram_en    = 1'b1;
        sram_we    = 1'b1;
        sram_addr  = {st_tag, r_idx, cnt};
        sram_wdata = st_line[cnt];
      end
      S_FILL, S_FWAIT: begin
        sram_en    = (state == S_FILL);
        sram_addr  = {r_tag, r_idx, cnt};
        st_wr_en   = cap_v;
        st_wr_off  = cap_off;
        st_wr_data = sram_rdata;
        st_fill_en = (state == S_FWAIT);
      end
      S_WALK: begin
        sram_en    = line_dirty;
        sram_we    = line_dirty;
        sram_addr  = {st_tag, wl, cnt};
        sram_wdata = st_line[cnt];
        st_clr_en  = !line_dirty || (cnt == LAST_OFF);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      r_dma         <= 1'b0;
      r_we          <= 1'b0;
      r_inv         <= 1'b0;
      r_addr        <= '0;
      r_wdata       <= '0;
      cnt           <= '0;
      wl            <= '0;
      cap_v         <= 1'b0;
      cap_off       <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
      dma_rsp_valid <= 1'b0;
      dma_rsp_rdata <= '0;
      cmd_done      <= 1'b0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      dma_rsp_valid <= 1'b0;
      cmd_done      <= 1'b0;
      cap_v         <= (state == S_FILL);
      cap_off       <= cnt;
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          wl  <= '0;
          if (dma_req_valid) begin
            r_dma   <= 1'b1;
            r_we    <= dma_req_we;
            r_addr  <= dma_req_addr;
            r_wdata <= dma_req_wdata;
            state   <= S_LOOK;
          end else if (cmd_req) begin
            r_inv <= cmd_inv;
            state <= S_WALK;
          end else if (cpu_req_valid) begin
            r_dma   <= 1'b0;
            r_we    <= cpu_req_we;
            r_addr  <= cpu_req_addr;
            r_wdata <= cpu_req_wdata;
            state   <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (r_dma) begin
            if (r_we || hit) begin
              dma_rsp_valid <= 1'b1;
              dma_rsp_rdata <= r_we ? r_wdata : st_line[r_off];
              state         <= S_IDLE;
            end else begin
              state <= S_DRD;
            end
          end else if (hit) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= r_we ? r_wdata : st_line[r_off];
            state         <= S_IDLE;
          end else begin
            cnt   <= '0;
            state <= line_dirty ? S_EVICT : S_FILL;
          end
        end
        S_DRD: begin
          dma_rsp_valid <= 1'b1;
          dma_rsp_rdata <= sram_rdata;
          state         <= S_IDLE;
        end
        S_EVICT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_OFF) state <= S_FILL;
        end
        S_FILL: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_OFF) state <= S_FWAIT;
        end
        S_FWAIT: state <= S_LOOK;
        S_WALK: begin
          if (line_dirty) cnt <= cnt + 1'b1;
          if (st_clr_en) begin
            wl <= wl + 1'b1;
            if (wl == LAST_LINE) begin
              cmd_done <= 1'b1;
              state    <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_wb_cache.sv
module snoop_wb_cache #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  input  logic              dma_req_valid,
  output logic              dma_req_ready,
  input  logic              dma_req_we,
  input  logic [ADDR_W-1:0] dma_req_addr,
  input  logic [DATA_W-1:0] dma_req_wdata,
  output logic              dma_rsp_valid,
  output logic [DATA_W-1:0] dma_rsp_rdata,
  output logic              sram_en,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  input  logic              cmd_req,
  input  logic              cmd_inv,
  output logic              cmd_done
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]              st_idx;
  logic                          st_valid, st_dirty;
  logic [TAG_W-1:0]              st_tag, st_fill_tag;
  logic [WORDS-1:0][DATA_W-1:0]  st_line;
  logic                          st_wr_en, st_wr_dirty, st_fill_en;
  logic                          st_clr_en, st_clr_inv;
  logic [OFF_W-1:0]              st_wr_off;
  logic [DATA_W-1:0]             st_wr_data;

  scb_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS)
  ) u_ctrl (
    .clk, .rst_n,
    .cpu_req_valid, .cpu_req_ready, .cpu_req_we, .cpu_req_addr, .cpu_req_wdata,
    .cpu_rsp_valid, .cpu_rsp_rdata,
    .dma_req_valid, .dma_req_ready, .dma_req_we, .dma_req_addr, .dma_req_wdata,
    .dma_rsp_valid, .dma_rsp_rdata,
    .sram_en, .sram_we, .sram_addr, .sram_wdata, .sram_rdata,
    .cmd_req, .cmd_inv, .cmd_done,
    .st_idx, .st_valid, .st_dirty, .st_tag, .st_line,
    .st_wr_en, .st_wr_off, .st_wr_data, .st_wr_dirty,
    .st_fill_en, .st_fill_tag, .st_clr_en, .st_clr_inv
  );

  scb_line_store #(
    .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)
  ) u_store (
    .clk, .rst_n,
    .idx      (st_idx),
    .rd_valid (st_valid),
    .rd_dirty (st_dirty),
    .rd_tag   (st_tag),
    .rd_line  (st_line),
    .wr_en    (st_wr_en),
    .wr_off   (st_wr_off),
    .wr_data  (st_wr_data),
    .wr_dirty (st_wr_dirty),
    .fill_en  (st_fill_en),
    .fill_tag (st_fill_tag),
    .clr_en   (st_clr_en),
    .clr_inv  (st_clr_inv)
  );
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              dma_req_valid,
  input logic              dma_req_ready,
  input logic              dma_req_we,
  input logic [ADDR_W-1:0] dma_req_addr,
  input logic [DATA_W-1:0] dma_req_wdata,
  input logic              dma_rsp_valid,
  input logic              sram_en,
  input logic              sram_we,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_wdata,
  input logic              cmd_done
);
  a_r8_dma_priority: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_valid |-> !cpu_req_ready);

  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> (!cpu_req_ready && !dma_req_ready));

  a_r9_rsp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rsp_valid && dma_rsp_valid));

  a_r2_dma_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_valid && dma_req_ready && !dma_req_we) |=> !(sram_en && sram_we));

  a_r3_dma_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_valid && dma_req_ready && dma_req_we) |=>
      (sram_en && sram_we && sram_addr == $past(dma_req_addr)
       && sram_wdata == $past(dma_req_wdata)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
endmodule

bind snoop_wb_cache scb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_scb_checker (
  .clk, .rst_n, .cpu_req_valid, .cpu_req_ready, .cpu_rsp_valid,
  .dma_req_valid, .dma_req_ready, .dma_req_we, .dma_req_addr, .dma_req_wdata,
  .dma_rsp_valid, .sram_en, .sram_we, .sram_addr, .sram_wdata, .cmd_done
);

// File: tb/snoop_wb_cache_bench.sv
module snoop_wb_cache_bench;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cpu_req_valid = 0, cpu_req_we = 0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_req_ready, cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          dma_req_valid = 0, dma_req_we = 0;
  logic [AW-1:0] dma_req_addr = '0;
  logic [DW-1:0] dma_req_wdata = '0;
  logic          dma_req_ready, dma_rsp_valid;
  logic [DW-1:0] dma_rsp_rdata;
  logic          sram_en, sram_we;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata;
  logic [DW-1:0] sram_rdata = '0;
  logic          cmd_req = 0, cmd_inv = 0, cmd_done;

  snoop_wb_cache u_snoop_wb_cache (.*);

  logic [DW-1:0] sram_mem [DEPTH];
  logic [DW-1:0] ref_mem  [DEPTH];
  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;

  initial for (int i = 0; i < DEPTH; i++) begin
    sram_mem[i] = 32'hA500_0000 + i;
    ref_mem[i]  = 32'hA500_0000 + i;
  end

  always @(posedge clk)
    if (sram_en) begin
      if (sram_we) sram_mem[sram_addr] <= sram_wdata;
      else         sram_rdata <= sram_mem[sram_addr];
    end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Every SRAM write must carry the latest coherent value (R5, R6, R3)
  always @(negedge clk) if (rst_n && sram_en) begin
    if (sram_we) begin
      n_wr++;
      chk("R5/R6 sram write value", sram_wdata, ref_mem[sram_addr]);
    end else n_rd++;
  end

  task automatic cpu_op(input bit we, input int a, input logic [DW-1:0] d, output logic [DW-1:0] q);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = we; cpu_req_addr = AW'(a); cpu_req_wdata = d;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    if (we) ref_mem[a] = d;
    @(negedge clk);
    cpu_req_valid = 0;
    while (!cpu_rsp_valid) @(negedge clk);
    q = cpu_rsp_rdata;
  endtask

  task automatic dma_op(input bit we, input int a, input logic [DW-1:0] d, output logic [DW-1:0] q);
    @(negedge clk);
    dma_req_valid = 1; dma_req_we = we; dma_req_addr = AW'(a); dma_req_wdata = d;
    #1;
    while (!dma_req_ready) begin @(negedge clk); #1; end
    if (we) ref_mem[a] = d;
    @(negedge clk);
    dma_req_valid = 0;
    while (!dma_rsp_valid) @(negedge clk);
    q = dma_rsp_rdata;
  endtask

  task automatic run_cmd(input bit inv);
    @(negedge clk);
    cmd_req = 1; cmd_inv = inv;
    do @(negedge clk); while (!cmd_done);
    cmd_req = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // A: tag 1 idx 2; B: tag 3 idx 2 (same line, R10); M: idx 11
  localparam int A = 73, B = 201, M = 300, C = 20;

  initial begin
    logic [DW-1:0] q, q2;
    int r0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 cpu_rsp_valid", DW'(cpu_rsp_valid), 0);
    chk("R12 dma_rsp_valid", DW'(dma_rsp_valid), 0);
    chk("R12 sram_en", DW'(sram_en), 0);
    chk("R12 cmd_done", DW'(cmd_done), 0);

    // clean miss fill
    r0 = n_rd; w0 = n_wr;
    cpu_op(0, A, 0, q);
    chk("R12 read data after reset", q, ref_mem[A]);
    chk("R12 fill reads on invalid line", DW'(n_rd - r0), 4);
    chk("R5 no writeback on clean miss", DW'(n_wr - w0), 0);

    // R1 write hit stays in cache
    w0 = n_wr;
    cpu_op(1, A, 32'h1111_0001, q);
    chk("R1 no sram write on hit", DW'(n_wr - w0), 0);
    chk("R1 sram keeps old word", sram_mem[A], 32'hA500_0000 + A);
    cpu_op(0, A, 0, q);
    chk("R1 cpu reads new word", q, 32'h1111_0001);

    // R2 dma snoop of dirty word
    w0 = n_wr; r0 = n_rd;
    dma_op(0, A, 0, q);
    chk("R2 dma sees cached word", q, 32'h1111_0001);
    chk("R2 no sram access", DW'((n_wr - w0) + (n_rd - r0)), 0);
    chk("R2 sram still stale", sram_mem[A], 32'hA500_0000 + A);

    // R3 dma write hit
    dma_op(1, A + 1, 32'h2222_0002, q);
    chk("R3 sram written", sram_mem[A + 1], 32'h2222_0002);
    r0 = n_rd;
    cpu_op(0, A + 1, 0, q);
    chk("R3 cached copy updated", q, 32'h2222_0002);
    chk("R3 still a hit", DW'(n_rd - r0), 0);

    // R4 dma write miss no allocate
    dma_op(1, M, 32'h3333_0003, q);
    chk("R4 sram written on miss", sram_mem[M], 32'h3333_0003);
    r0 = n_rd;
    cpu_op(0, M, 0, q);
    chk("R4 cpu refills after dma miss", DW'(n_rd - r0), 4);
    chk("R4 data", q, 32'h3333_0003);

    // R11 dma read miss
    r0 = n_rd;
    dma_op(0, 500, 0, q);
    chk("R11 dma miss data", q, ref_mem[500]);
    chk("R11 single sram read", DW'(n_rd - r0), 1);

    // R5 / R10 eviction of dirty line by conflicting tag
    w0 = n_wr; r0 = n_rd;
    cpu_op(0, B, 0, q);
    chk("R5 data after evict", q, ref_mem[B]);
    chk("R5 four writebacks", DW'(n_wr - w0), 4);
    chk("R5 four fill reads", DW'(n_rd - r0), 4);
    chk("R10 old word now in sram", sram_mem[A], 32'h1111_0001);

    // R6 writeback all
    cpu_op(1, B, 32'h4444_0004, q);
    cpu_op(1, C, 32'h5555_0005, q);
    w0 = n_wr;
    run_cmd(0);
    chk("R6 dirty lines written", DW'(n_wr - w0), 8);
    chk("R6 sram B", sram_mem[B], 32'h4444_0004);
    chk("R6 sram C", sram_mem[C], 32'h5555_0005);
    r0 = n_rd;
    cpu_op(0, B, 0, q);
    chk("R6 line stays valid", DW'(n_rd - r0), 0);
    w0 = n_wr;
    run_cmd(0);
    chk("R6 dirty cleared", DW'(n_wr - w0), 0);

    // R7 writeback invalidate
    cpu_op(1, B, 32'h6666_0006, q);
    run_cmd(1);
    chk("R7 sram B", sram_mem[B], 32'h6666_0006);
    r0 = n_rd;
    cpu_op(0, B, 0, q);
    chk("R7 refill after invalidate", DW'(n_rd - r0), 4);
    chk("R7 data", q, 32'h6666_0006);

    // R8 simultaneous requests
    fork
      cpu_op(0, C, 0, q);
      dma_op(0, A, 0, q2);
      begin
        @(negedge clk); #2;
        chk("R8 dma granted", DW'(dma_req_ready), 1);
        chk("R8 cpu held", DW'(cpu_req_ready), 0);
      end
    join
    chk("R9 cpu data", q, ref_mem[C]);
    chk("R9 dma data", q2, ref_mem[A]);

    // R9 random mixed traffic
    for (int k = 0; k < 300; k++) begin
      int a;
      bit we, dm;
      logic [DW-1:0] d;
      a  = $urandom_range(0, 255);
      we = $urandom_range(0, 1);
      dm = $urandom_range(0, 1);
      d  = $urandom;
      if (dm) dma_op(we, a, d, q); else cpu_op(we, a, d, q);
      if (!we) chk(dm ? "R9 random dma read" : "R9 random cpu read", q, ref_mem[a]);
      if (k % 100 == 99) run_cmd(k % 200 == 199);
    end
    run_cmd(0);
    for (int i = 0; i < 256; i++)
      if (sram_mem[i] !== ref_mem[i]) chk("R6 sram after final writeback", sram_mem[i], ref_mem[i]);
    n_chk++;

    summary();
    $finish;
  end
endmodule